// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block drives an eight-digit multiplexed seven-segment LED display that has a decimal point on every digit. It owns a read port into an eight-byte display memory kept outside the block. The block visits the digits one at a time and lights each one for a fixed slot. Every slot opens with a dark interval, so the segment lines settle before the next digit line turns on. The system clock feeds a counter that sets both the slot length and the dark-interval length. With a 125 MHz clock, the default values give about a 250 Hz refresh per digit and a gap of about 10 µs.

Each stored byte becomes a segment pattern in one of three formats. Hexadecimal decode and the alternate numeric/letter decode use the low nibble as a glyph code. Raw mode passes the byte bits straight to individual segments. A shutdown input turns every driver off and freezes the scan. The memory stays writable during shutdown because it sits outside the block. When shutdown is released, the scan restarts at digit 0 with a new dark interval.

The build-time parameter `COMMON_ANODE` selects the electrical sense of the digit and segment lines. The memory read port is a plain combinational address/data pair. The block places an address and takes the data in the same cycle, so there is no valid/ready handshake and no back-pressure.

Top module: `led_scan_driver`

## Requirements
- R1: While reset is asserted, and on the first sample after it, every digit line and segment line is at its off level.
- R2: Scan order and slots.
  - Time is divided into slots of `SLOT_CYCLES` clocks.
  - Slots visit digits 0,1,…,7 and then wrap to 0.
  - During slot k, digit line k is the one that may light, and `mem_addr` equals k.
- R3: Dark interval.
  - For the first `BLANK_CYCLES` clocks of every slot, all digit and segment lines are off.
  - Port outputs lag the internal slot position by one clock.
- R4: At no time is more than one digit line at its on level.
- R5: Hexadecimal decode (`raw_mode`=0, `hex_sel`=1) shows codes 0–15 as 0–9, A, b, C, d, E, F.
- R6: Alternate decode (`raw_mode`=0, `hex_sel`=0) behaves as follows.
  - Codes 0–9 show the numerals.
  - Code 10 shows a dash (segment g only).
  - Codes 11, 12, 13 and 14 show E, H, L and P.
  - Code 15 shows a fully dark digit.
- R7: Decimal point and unused bits in both decode modes.
  - The decimal point follows byte bit 7, active-high (1 = lit).
  - Byte bits 6:4 have no effect.
- R8: Raw mode (`raw_mode`=1) maps byte bits to segments as follows.
  - bit6→a, bit5→b, bit4→c, bit3→e, bit2→g, bit1→f, bit0→d, with 1 = lit.
  - bit7 drives the decimal point with inverted sense (0 = lit).
- R9: Shutdown behaviour.
  - From the clock edge that samples `shutdown` high, all lines are off.
  - The scan position is held at digit 0, slot start.
  - Memory changes made meanwhile appear once the scan resumes.
- R10: After `shutdown` falls, the first slot is digit 0, and it begins with a full dark interval.
- R11: Line polarity.
  - `seg_out` bit order is {dp,g,f,e,d,c,b,a}.
  - With `COMMON_ANODE`=0, a digit is on when its line is 0 and a segment is on when its line is 1.
  - With `COMMON_ANODE`=1, both senses are inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the scan timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| shutdown | input | 1 | 1 = drivers off and scan frozen |
| raw_mode | input | 1 | 1 = raw segment pass-through |
| hex_sel | input | 1 | In decode mode: 1 = hexadecimal, 0 = alternate set |
| mem_addr | output | 3 | Display memory read address (current digit) |
| mem_data | input | 8 | Display memory byte at `mem_addr`, same cycle |
| seg_out | output | 8 | Segment lines {dp,g,f,e,d,c,b,a} |
| dig_out | output | 8 | Digit lines, bit k = digit k |

## Verification
Every port result is registered once. The pattern for a given slot position shows up on the pins one clock after the counter reaches that position. The bench therefore counts clock edges since reset release, or since the last edge that sampled `shutdown` high. From that count it derives digit = ((n−1)/SLOT) mod 8 and position = (n−1) mod SLOT. An edge that samples shutdown or reset zeroes the count, so the dark result is due at the very next sample. Inputs change only at the falling edge and outputs are compared at the falling edge. Each expected value therefore pairs with the memory and mode values present at the preceding rising edge.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  typedef enum logic [1:0] {
    FMT_ALT = 2'd0,
    FMT_HEX = 2'd1,
    FMT_RAW = 2'd2
  } glyph_fmt_e;

  localparam int SEG_LINES = 8;

  typedef logic [SEG_LINES-1:0] seg_pat_t;

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int NUM_DIGITS   = 8,
  parameter int SLOT_CYCLES  = 62500,
  parameter int BLANK_CYCLES = 1250,
  localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  output logic [IDX_W-1:0] digit_idx,
  output logic             lit
);

  localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(SLOT_CYCLES - 1);
  localparam logic [CNT_W-1:0] DARK_END  = CNT_W'(BLANK_CYCLES);
  localparam logic [IDX_W-1:0] LAST_DIG  = IDX_W'(NUM_DIGITS - 1);

  logic [CNT_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n || halt) begin
      pos_q     <= '0;
      digit_idx <= '0;
    end else if (pos_q == LAST_POS) begin
      pos_q     <= '0;
      digit_idx <= (digit_idx == LAST_DIG) ? '0 : digit_idx + 1'b1;
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign lit = (pos_q >= DARK_END);

  // R2: digit index never leaves the populated range
  assert_index_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    digit_idx <= LAST_DIG);

  // R2: the digit only changes at the end of a slot
  assert_index_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && pos_q != LAST_POS) |=> $stable(digit_idx));

  // R2: after the last digit the scan wraps to digit 0
  assert_index_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && pos_q == LAST_POS && digit_idx == LAST_DIG) |=> digit_idx == '0);

  // R10: a halted cycle leaves the scan at digit 0 in its dark interval
  assert_restart_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (digit_idx == '0 && !lit));

endmodule

// File: rtl/glyph_decoder.sv
module glyph_decoder
  import led_scan_pkg::*;
(
  input  logic [7:0] code_byte,
  input  glyph_fmt_e fmt,
  output seg_pat_t   seg_lit
);

  // pattern order {g,f,e,d,c,b,a}
  logic [6:0] hex_pat;
  logic [6:0] alt_pat;

  always_comb begin
    unique case (code_byte[3:0])
      4'h0: hex_pat = 7'h3F;
      4'h1: hex_pat = 7'h06;
      4'h2: hex_pat = 7'h5B;
      4'h3: hex_pat = 7'h4F;
      4'h4: hex_pat = 7'h66;
      4'h5: hex_pat = 7'h6D;
      4'h6: hex_pat = 7'h7D;
      4'h7: hex_pat = 7'h07;
      4'h8: hex_pat = 7'h7F;
      4'h9: hex_pat = 7'h6F;
      4'hA: hex_pat = 7'h77;
      4'hB: hex_pat = 7'h7C;
      4'hC: hex_pat = 7'h39;
      4'hD: hex_pat = 7'h5E;
      4'hE: hex_pat = 7'h79;
      default: hex_pat = 7'h71;
    endcase
  end

  always_comb begin
    if (code_byte[3:0] < 4'd10) begin
      alt_pat = hex_pat;
    end else begin
      unique case (code_byte[3:0])
        4'hA: alt_pat = 7'h40;
        4'hB: alt_pat = 7'h79;
        4'hC: alt_pat = 7'h76;
        4'hD: alt_pat = 7'h38;
        4'hE: alt_pat = 7'h73;
        default: alt_pat = 7'h00;
      endcase
    end
  end

  always_comb begin
    unique case (fmt)
      FMT_HEX: seg_lit = {code_byte[7], hex_pat};
      FMT_ALT: seg_lit = {code_byte[7], alt_pat};
      default: seg_lit = {~code_byte[7],   // dp, inverted sense
                          code_byte[2],    // g
                          code_byte[1],    // f
                          code_byte[3],    // e
                          code_byte[0],    // d
                          code_byte[4],    // c
                          code_byte[5],    // b
                          code_byte[6]};   // a
    endcase
  end

endmodule

// File: rtl/drive_stage.sv
module drive_stage
  import led_scan_pkg::*;
#(
  parameter int NUM_DIGITS   = 8,
  parameter bit COMMON_ANODE = 1'b0,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  halt,
  input  logic                  lit,
  input  logic [IDX_W-1:0]      digit_idx,
  input  seg_pat_t              seg_lit,
  output logic [NUM_DIGITS-1:0] dig_out,
  output seg_pat_t              seg_out
);

  logic [NUM_DIGITS-1:0] dig_on_q;
  seg_pat_t              seg_on_q;

  always_ff @(posedge clk) begin
    if (!rst_n || halt || !lit) begin
      dig_on_q <= '0;
      seg_on_q <= '0;
    end else begin
      dig_on_q <= NUM_DIGITS'(1) << digit_idx;
      seg_on_q <= seg_lit;
    end
  end

  generate
    if (COMMON_ANODE) begin : g_anode
      assign dig_out = dig_on_q;
      assign seg_out = ~seg_on_q;
    end else begin : g_cathode
      assign dig_out = ~dig_on_q;
      assign seg_out = seg_on_q;
    end
  endgenerate

  // R4: never more than one digit lit
  assert_single_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_on_q));

  // R3: a lit segment always comes with a lit digit
  assert_seg_needs_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_on_q != '0) |-> (dig_on_q != '0));

  // R9: shutdown darkens every line on the next cycle
  assert_shutdown_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (dig_on_q == '0 && seg_on_q == '0));

  // R3: dark interval yields dark outputs one cycle later
  assert_blank_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lit |=> (dig_on_q == '0));

endmodule

// File: rtl/led_scan_driver.sv
module led_scan_driver
  import led_scan_pkg::*;
#(
  parameter int NUM_DIGITS   = 8,
  parameter int SLOT_CYCLES  = 62500,
  parameter int BLANK_CYCLES = 1250,
  parameter bit COMMON_ANODE = 1'b0,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shutdown,
  input  logic                  raw_mode,
  input  logic                  hex_sel,
  output logic [IDX_W-1:0]      mem_addr,
  input  logic [7:0]            mem_data,
  output logic [7:0]            seg_out,
  output logic [NUM_DIGITS-1:0] dig_out
);

  logic [IDX_W-1:0] digit_idx;
  logic             lit;
  glyph_fmt_e       fmt;
  seg_pat_t         seg_lit;

  assign fmt      = raw_mode ? FMT_RAW : (hex_sel ? FMT_HEX : FMT_ALT);
  assign mem_addr = digit_idx;

  scan_timer #(
    .NUM_DIGITS  (NUM_DIGITS),
    .SLOT_CYCLES (SLOT_CYCLES),
    .BLANK_CYCLES(BLANK_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (shutdown),
    .digit_idx(digit_idx),
    .lit      (lit)
  );

  glyph_decoder u_decode (
    .code_byte(mem_data),
    .fmt      (fmt),
    .seg_lit  (seg_lit)
  );

  drive_stage #(
    .NUM_DIGITS  (NUM_DIGITS),
    .COMMON_ANODE(COMMON_ANODE)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (shutdown),
    .lit      (lit),
    .digit_idx(digit_idx),
    .seg_lit  (seg_lit),
    .dig_out  (dig_out),
    .seg_out  (seg_out)
  );

endmodule

// File: tb/led_scan_driver_bench.sv
module led_scan_driver_bench;

  localparam int SLOT  = 8;
  localparam int BLANK = 2;
  localparam int NDIG  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic       rst_n = 1'b0;
  logic       sd = 1'b0;
  logic       raw = 1'b0;
  logic       hex = 1'b1;
  logic [7:0] mem [NDIG];
  logic [2:0] addr_cc, addr_ca;
  logic [7:0] seg_cc, seg_ca, dig_cc, dig_ca;

  int n = 0;
  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  led_scan_driver #(.SLOT_CYCLES(SLOT), .BLANK_CYCLES(BLANK), .COMMON_ANODE(1'b0))
    u_led_scan_driver (.clk(clk), .rst_n(rst_n), .shutdown(sd), .raw_mode(raw),
      .hex_sel(hex), .mem_addr(addr_cc), .mem_data(mem[addr_cc]),
      .seg_out(seg_cc), .dig_out(dig_cc));

  led_scan_driver #(.SLOT_CYCLES(SLOT), .BLANK_CYCLES(BLANK), .COMMON_ANODE(1'b1))
    u_led_scan_driver_ca (.clk(clk), .rst_n(rst_n), .shutdown(sd), .raw_mode(raw),
      .hex_sel(hex), .mem_addr(addr_ca), .mem_data(mem[addr_ca]),
      .seg_out(seg_ca), .dig_out(dig_ca));

  function automatic logic [7:0] letters(string s);
    logic [7:0] r = '0;
    for (int i = 0; i < s.len(); i++) r[int'(s[i]) - 97] = 1'b1;
    return r;
  endfunction

  function automatic string hex_shape(int c);
    case (c)
      0: return "abcdef";   1: return "bc";      2: return "abdeg";
      3: return "abcdg";    4: return "bcfg";    5: return "acdfg";
      6: return "acdefg";   7: return "abc";     8: return "abcdefg";
      9: return "abcdfg";   10: return "abcefg"; 11: return "cdefg";
      12: return "adef";    13: return "bcdeg";  14: return "adefg";
      default: return "aefg";
    endcase
  endfunction

  function automatic string alt_shape(int c);
    case (c)
      10: return "g";  11: return "adefg"; 12: return "bcefg";
      13: return "def"; 14: return "abefg"; 15: return "";
      default: return hex_shape(c);
    endcase
  endfunction

  // expected active-high pattern {dp,g,f,e,d,c,b,a}
  function automatic logic [7:0] want_seg(logic [7:0] b);
    logic [7:0] r;
    if (raw) begin   // R8
      r = '0;
      r[0] = b[6]; r[1] = b[5]; r[2] = b[4]; r[3] = b[0];
      r[4] = b[3]; r[5] = b[1]; r[6] = b[2]; r[7] = !b[7];
    end else begin   // R5 R6 R7
      r = letters(hex ? hex_shape(int'(b[3:0])) : alt_shape(int'(b[3:0])));
      r[7] = b[7];
    end
    return r;
  endfunction

  task automatic check(string tag_in);
    logic [7:0] ed, es;
    string tag;
    int d, p;
    ed = '0; es = '0; tag = tag_in;
    if (n == 0) begin
      tag = rst_n ? "R9" : "R1";
    end else begin
      d = ((n - 1) / SLOT) % NDIG;
      p = (n - 1) % SLOT;
      if (p >= BLANK) begin
        ed = 8'(1) << d;
        es = want_seg(mem[d]);
      end else if (tag_in == "") begin
        tag = "R3";
      end
      if (tag == "") tag = raw ? "R8" : (hex ? "R5 R7" : "R6 R7");
    end
    vectors++;
    if (dig_cc !== ~ed || seg_cc !== es) begin
      misses++;
      $display("FAIL %s R2 R4 n=%0d cathode dig=%h seg=%h expected dig=%h seg=%h",
               tag, n, dig_cc, seg_cc, ~ed, es);
    end
    vectors++;
    if (dig_ca !== ed || seg_ca !== ~es) begin
      misses++;
      $display("FAIL R11 %s n=%0d anode dig=%h seg=%h expected dig=%h seg=%h",
               tag, n, dig_ca, seg_ca, ed, ~es);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    if (!rst_n || sd) n = 0; else n++;
    @(negedge clk);
    check(tag);
  endtask

  task automatic run(int cycles, string tag);
    for (int i = 0; i < cycles; i++) step(tag);
  endtask

  task automatic fill(int seed, bit junk);
    for (int k = 0; k < NDIG; k++) begin
      mem[k] = 8'((seed + k) * 37 + seed * 5);
      if (!junk) mem[k][6:4] = 3'b000;
    end
  endtask

  initial begin
    for (int k = 0; k < NDIG; k++) mem[k] = 8'h00;
    @(negedge clk);
    check("R1");                      // R1: during reset
    run(3, "R1");
    rst_n = 1'b1;
    // R5 R7: hex decode, all 16 codes, dp and junk bits varied
    raw = 1'b0; hex = 1'b1;
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < NDIG; k++)
        mem[k] = {1'(k + r), 3'(k * 3 + r), 4'(r * 8 + k)};
      run(SLOT * NDIG, "");
    end
    // R6 R7: alternate decode, all 16 codes
    hex = 1'b0;
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < NDIG; k++)
        mem[k] = {1'(k + r + 1), 3'(k * 5), 4'(r * 8 + k)};
      run(SLOT * NDIG, "");
    end
    // R8: raw pass-through, several byte patterns
    raw = 1'b1;
    for (int r = 0; r < 4; r++) begin
      fill(r * 11 + 1, 1'b1);
      if (r == 3) mem[0] = 8'h80;
      run(SLOT * NDIG, "R8");
    end
    // R9: shutdown mid-slot, memory rewritten while dark
    run(SLOT * 3 + 5, "R8");
    sd = 1'b1;
    raw = 1'b0; hex = 1'b1;
    run(6, "R9");
    fill(99, 1'b0);
    run(4, "R9");
    // R10: restart at digit 0 behind a fresh dark interval
    sd = 1'b0;
    run(SLOT * NDIG + SLOT, "R10");
    // shutdown toggled for a single edge
    sd = 1'b1;
    step("R9");
    sd = 1'b0;
    hex = 1'b0;
    run(SLOT * 2, "R10");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired n=%0d expected completion", n);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule